// File: doc/BRIEF.md
# Multi-Cycle Processor Control Sequencer

This block is the hardwired sequencer that steers the datapath of a multi-cycle 32-bit load/store processor. A registered state is decoded into one fixed set of control levels per state (a Moore machine). The 6-bit opcode held in the instruction register only chooses which state comes next. Every instruction begins with two shared steps, FETCH and DECODE. After DECODE the opcode selects one of four paths: memory access, register-register, branch-on-equal or jump. Each path ends by returning to FETCH.

The states are FETCH, DECODE, MADDR (memory address), LDRD (load read), LDWB (load writeback), STWR (store write), RREX (register-register execute), RRWB (register-register writeback), BREQ (branch compare) and JUMP. These are the transitions:
- FETCH to DECODE, always.
- DECODE to MADDR for load or store, to RREX for register-register, to BREQ for branch, to JUMP for jump, and to FETCH for any other opcode.
- MADDR to STWR for store, and to LDRD otherwise.
- LDRD to LDWB, and RREX to RRWB.
- LDWB, STWR, RRWB, BREQ and JUMP to FETCH.

Top module: `mcc_ctrl`

## Requirements
- R1: A synchronous reset puts the sequencer in FETCH. The outputs show the FETCH encoding in the cycle after the reset edge.
- R2: FETCH drives mem_rd=1, ir_load=1, pc_load=1, addr_sel=0, opa_sel=0, opb_sel=01, alu_class=00 and pc_src=00. All other outputs are 0.
- R3: FETCH is always followed by DECODE. DECODE drives opa_sel=0, opb_sel=11 and alu_class=00, and all other outputs are 0.
- R4: From DECODE the opcode picks the next state. 0x23 and 0x2B go to MADDR, 0x00 goes to RREX, 0x04 goes to BREQ, 0x02 goes to JUMP, and any other value goes to FETCH.
- R5: MADDR drives opa_sel=1 and opb_sel=10, with everything else 0. It then goes to STWR when the opcode is 0x2B, and to LDRD otherwise.
- R6: LDRD drives mem_rd=1 and addr_sel=1, then goes to LDWB. LDWB drives rf_write=1, wb_sel=1 and dst_sel=0, then goes to FETCH.
- R7: STWR drives mem_wr=1 and addr_sel=1, then goes to FETCH.
- R8: RREX drives opa_sel=1, opb_sel=00 and alu_class=10, then goes to RRWB. RRWB drives rf_write=1, dst_sel=1 and wb_sel=0, then goes to FETCH.
- R9: BREQ drives opa_sel=1, opb_sel=00, alu_class=01, pc_load_if_eq=1 and pc_src=01, then goes to FETCH.
- R10: JUMP drives pc_load=1 and pc_src=10, then goes to FETCH.
- R11: mem_rd and mem_wr are never high together. pc_load and pc_load_if_eq are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| opcode | input | 6 | Opcode field from the instruction register |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| addr_sel | output | 1 | Memory address source: 0 = PC, 1 = ALU output register |
| ir_load | output | 1 | Instruction register write enable |
| pc_load | output | 1 | Unconditional PC write |
| pc_load_if_eq | output | 1 | PC write when the ALU reports zero |
| pc_src | output | 2 | PC source: 00 ALU result, 01 ALU output register, 10 jump target |
| opa_sel | output | 1 | ALU operand A: 0 = PC, 1 = register A |
| opb_sel | output | 2 | ALU operand B: 00 reg B, 01 constant 4, 10 immediate, 11 immediate shifted by 2 |
| alu_class | output | 2 | ALU operation class: 00 add, 01 subtract-compare, 10 function field |
| rf_write | output | 1 | Register file write enable |
| dst_sel | output | 1 | Destination register: 0 = rt field, 1 = rd field |
| wb_sel | output | 1 | Writeback data: 0 = ALU output, 1 = memory data |

## Verification
The assertions assume that the opcode does not change from the DECODE cycle until the sequencer is back in FETCH. This matches the real datapath, where the instruction register is written only in FETCH. The sequence checks on the memory-address path read the opcode one cycle before the store or load step, so they rely on this assumption. The stimulus changes the opcode only in cycles where the reference model is in FETCH. A reset is applied in the middle of a load, and undefined opcodes are included so that the fall-back path is covered.

// File: rtl/mcc_pkg.sv
package mcc_pkg;

    localparam int OPC_W   = 6;
    localparam int STATE_W = 4;

    localparam logic [OPC_W-1:0] OPC_LOAD  = 6'h23;
    localparam logic [OPC_W-1:0] OPC_STORE = 6'h2B;
    localparam logic [OPC_W-1:0] OPC_RR    = 6'h00;
    localparam logic [OPC_W-1:0] OPC_BEQ   = 6'h04;
    localparam logic [OPC_W-1:0] OPC_JUMP  = 6'h02;

    typedef enum logic [STATE_W-1:0] {
        ST_FETCH  = 4'd0,
        ST_DECODE = 4'd1,
        ST_MADDR  = 4'd2,
        ST_LDRD   = 4'd3,
        ST_LDWB   = 4'd4,
        ST_STWR   = 4'd5,
        ST_RREX   = 4'd6,
        ST_RRWB   = 4'd7,
        ST_BREQ   = 4'd8,
        ST_JUMP   = 4'd9
    } ctl_state_e;

    typedef struct packed {
        logic       mem_rd;
        logic       mem_wr;
        logic       addr_sel;
        logic       ir_load;
        logic       pc_load;
        logic       pc_load_if_eq;
        logic [1:0] pc_src;
        logic       opa_sel;
        logic [1:0] opb_sel;
        logic [1:0] alu_class;
        logic       rf_write;
        logic       dst_sel;
        logic       wb_sel;
    } ctl_word_t;

endpackage

// File: rtl/mcc_state_reg.sv
module mcc_state_reg
    import mcc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  ctl_state_e nxt,
    output ctl_state_e cur
);
    always_ff @(posedge clk) begin
        if (rst) cur <= ST_FETCH;
        else     cur <= nxt;
    end
endmodule

// File: rtl/mcc_next_state.sv
module mcc_next_state
    import mcc_pkg::*;
(
    input  ctl_state_e       cur,
    input  logic [OPC_W-1:0] opcode,
    output ctl_state_e       nxt
);
    always_comb begin
        unique case (cur)
            ST_FETCH:  nxt = ST_DECODE;
            ST_DECODE: begin
                if (opcode == OPC_LOAD || opcode == OPC_STORE) nxt = ST_MADDR;
                else if (opcode == OPC_RR)                     nxt = ST_RREX;
                else if (opcode == OPC_BEQ)                    nxt = ST_BREQ;
                else if (opcode == OPC_JUMP)                   nxt = ST_JUMP;
                else                                           nxt = ST_FETCH;
            end
            ST_MADDR:  nxt = (opcode == OPC_STORE) ? ST_STWR : ST_LDRD;
            ST_LDRD:   nxt = ST_LDWB;
            ST_RREX:   nxt = ST_RRWB;
            ST_LDWB, ST_STWR, ST_RRWB, ST_BREQ, ST_JUMP: nxt = ST_FETCH;
            default:   nxt = ST_FETCH;
        endcase
    end
endmodule

// File: rtl/mcc_out_decode.sv
module mcc_out_decode
    import mcc_pkg::*;
(
    input  ctl_state_e cur,
    output ctl_word_t  cw
);
    always_comb begin
        cw = '0;
        unique case (cur)
            ST_FETCH: begin
                cw.mem_rd  = 1'b1;
                cw.ir_load = 1'b1;
                cw.pc_load = 1'b1;
                cw.opb_sel = 2'b01;
            end
            ST_DECODE: cw.opb_sel = 2'b11;
            ST_MADDR: begin
                cw.opa_sel = 1'b1;
                cw.opb_sel = 2'b10;
            end
            ST_LDRD: begin
                cw.mem_rd   = 1'b1;
                cw.addr_sel = 1'b1;
            end
            ST_LDWB: begin
                cw.rf_write = 1'b1;
                cw.wb_sel   = 1'b1;
            end
            ST_STWR: begin
                cw.mem_wr   = 1'b1;
                cw.addr_sel = 1'b1;
            end
            ST_RREX: begin
                cw.opa_sel   = 1'b1;
                cw.alu_class = 2'b10;
            end
            ST_RRWB: begin
                cw.rf_write = 1'b1;
                cw.dst_sel  = 1'b1;
            end
            ST_BREQ: begin
                cw.opa_sel       = 1'b1;
                cw.alu_class     = 2'b01;
                cw.pc_load_if_eq = 1'b1;
                cw.pc_src        = 2'b01;
            end
            ST_JUMP: begin
                cw.pc_load = 1'b1;
                cw.pc_src  = 2'b10;
            end
            default: cw = '0;
        endcase
    end
endmodule

// File: rtl/mcc_ctrl.sv
module mcc_ctrl
    import mcc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [OPC_W-1:0] opcode,
    output logic             mem_rd,
    output logic             mem_wr,
    output logic             addr_sel,
    output logic             ir_load,
    output logic             pc_load,
    output logic             pc_load_if_eq,
    output logic [1:0]       pc_src,
    output logic             opa_sel,
    output logic [1:0]       opb_sel,
    output logic [1:0]       alu_class,
    output logic             rf_write,
    output logic             dst_sel,
    output logic             wb_sel
);
    ctl_state_e cur_q;
    ctl_state_e nxt_d;
    ctl_word_t  cw;

    mcc_state_reg u_state (.clk(clk), .rst(rst), .nxt(nxt_d), .cur(cur_q));
    mcc_next_state u_next (.cur(cur_q), .opcode(opcode), .nxt(nxt_d));
    mcc_out_decode u_out (.cur(cur_q), .cw(cw));

    assign mem_rd        = cw.mem_rd;
    assign mem_wr        = cw.mem_wr;
    assign addr_sel      = cw.addr_sel;
    assign ir_load       = cw.ir_load;
    assign pc_load       = cw.pc_load;
    assign pc_load_if_eq = cw.pc_load_if_eq;
    assign pc_src        = cw.pc_src;
    assign opa_sel       = cw.opa_sel;
    assign opb_sel       = cw.opb_sel;
    assign alu_class     = cw.alu_class;
    assign rf_write      = cw.rf_write;
    assign dst_sel       = cw.dst_sel;
    assign wb_sel        = cw.wb_sel;
endmodule

// File: rtl/mcc_ctrl_chk.sv
module mcc_ctrl_chk
    import mcc_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic [OPC_W-1:0] opcode,
    input logic             mem_rd,
    input logic             mem_wr,
    input logic             addr_sel,
    input logic             ir_load,
    input logic             pc_load,
    input logic             pc_load_if_eq,
    input logic [1:0]       pc_src,
    input logic             opa_sel,
    input logic [1:0]       opb_sel,
    input logic [1:0]       alu_class,
    input logic             rf_write,
    input logic             dst_sel,
    input logic             wb_sel
);
    // R1
    reset_to_fetch_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (ir_load && mem_rd && pc_load));

    // R3
    fetch_then_decode_chk: assert property (@(posedge clk) disable iff (rst)
        ir_load |=> (opb_sel == 2'b11 && !opa_sel && !mem_rd));

    // R5
    maddr_store_chk: assert property (@(posedge clk) disable iff (rst)
        (opb_sel == 2'b10 && opcode == OPC_STORE) |=> (mem_wr && addr_sel));

    // R6
    maddr_load_chk: assert property (@(posedge clk) disable iff (rst)
        (opb_sel == 2'b10 && opcode == OPC_LOAD) |=> (mem_rd && addr_sel && !mem_wr));

    // R7
    store_ends_chk: assert property (@(posedge clk) disable iff (rst)
        mem_wr |=> ir_load);

    // R8
    rfwrite_ends_chk: assert property (@(posedge clk) disable iff (rst)
        rf_write |=> ir_load);

    // R9
    branch_ends_chk: assert property (@(posedge clk) disable iff (rst)
        pc_load_if_eq |=> ir_load);

    // R10
    jump_ends_chk: assert property (@(posedge clk) disable iff (rst)
        (pc_load && pc_src == 2'b10) |=> ir_load);

    // R11
    mem_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr));

    // R11
    pc_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(pc_load && pc_load_if_eq));
endmodule

bind mcc_ctrl mcc_ctrl_chk chk_i (.*);

// File: tb/mcc_ctrl_tb_top.sv
`timescale 1ns/1ps
module mcc_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [5:0] opcode = 6'h00;
    logic       mem_rd, mem_wr, addr_sel, ir_load, pc_load, pc_load_if_eq;
    logic [1:0] pc_src, opb_sel, alu_class;
    logic       opa_sel, rf_write, dst_sel, wb_sel;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int ms = 0;
    bit started = 1'b0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    mcc_ctrl dut_i (
        .clk(clk), .rst(rst), .opcode(opcode),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .addr_sel(addr_sel), .ir_load(ir_load),
        .pc_load(pc_load), .pc_load_if_eq(pc_load_if_eq), .pc_src(pc_src),
        .opa_sel(opa_sel), .opb_sel(opb_sel), .alu_class(alu_class),
        .rf_write(rf_write), .dst_sel(dst_sel), .wb_sel(wb_sel)
    );

    // Behavioural reference: state number 0..9 stepped by the requirement text
    always @(posedge clk) begin
        started <= 1'b1;
        if (rst) ms <= 0;
        else begin
            case (ms)
                0: ms <= 1;
                1: begin
                    if (opcode == 6'h23 || opcode == 6'h2B) ms <= 2;
                    else if (opcode == 6'h00) ms <= 6;
                    else if (opcode == 6'h04) ms <= 8;
                    else if (opcode == 6'h02) ms <= 9;
                    else ms <= 0;
                end
                2: ms <= (opcode == 6'h2B) ? 5 : 3;
                3: ms <= 4;
                6: ms <= 7;
                default: ms <= 0;
            endcase
        end
    end

    // Packed order: rd wr addr irl pcl pceq pcsrc[2] opa opb[2] alu[2] rfw dst wb
    function automatic logic [15:0] expect_word(input int s);
        case (s)
            0: return {1'b1,1'b0,1'b0,1'b1,1'b1,1'b0,2'b00,1'b0,2'b01,2'b00,1'b0,1'b0,1'b0};
            1: return {1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,2'b00,1'b0,2'b11,2'b00,1'b0,1'b0,1'b0};
            2: return {1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,2'b00,1'b1,2'b10,2'b00,1'b0,1'b0,1'b0};
            3: return {1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,2'b00,1'b0,2'b00,2'b00,1'b0,1'b0,1'b0};
            4: return {1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,2'b00,1'b0,2'b00,2'b00,1'b1,1'b0,1'b1};
            5: return {1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,2'b00,1'b0,2'b00,2'b00,1'b0,1'b0,1'b0};
            6: return {1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,2'b00,1'b1,2'b00,2'b10,1'b0,1'b0,1'b0};
            7: return {1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,2'b00,1'b0,2'b00,2'b00,1'b1,1'b1,1'b0};
            8: return {1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,2'b01,1'b1,2'b00,2'b01,1'b0,1'b0,1'b0};
            default: return {1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,2'b10,1'b0,2'b00,2'b00,1'b0,1'b0,1'b0};
        endcase
    endfunction

    function automatic string req_of(input int s);
        case (s)
            0: return "R1/R2/R4";
            1: return "R3";
            2: return "R5";
            3, 4: return "R6";
            5: return "R7";
            6, 7: return "R8";
            8: return "R9";
            default: return "R10";
        endcase
    endfunction

    wire [15:0] act_word = {mem_rd, mem_wr, addr_sel, ir_load, pc_load, pc_load_if_eq,
                            pc_src, opa_sel, opb_sel, alu_class, rf_write, dst_sel, wb_sel};

    // Compare every cycle, away from the active edge
    always @(negedge clk) begin
        if (started && !done) begin
            cycles++;
            checks++;
            if (act_word !== expect_word(ms)) begin
                errors++;
                $display("FAIL %s state %0d: actual %b expected %b", req_of(ms), ms,
                         act_word, expect_word(ms));
            end
            checks++;
            if ((mem_rd && mem_wr) || (pc_load && pc_load_if_eq)) begin
                errors++;
                $display("FAIL R11: actual rd=%b wr=%b pcl=%b pceq=%b expected no overlap",
                         mem_rd, mem_wr, pc_load, pc_load_if_eq);
            end
            if (cycles > 5000) begin
                errors++;
                $display("FAIL watchdog: actual %0d cycles expected under 5000", cycles);
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        end
    end

    task automatic run_instr(input logic [5:0] op);
        @(negedge clk);
        while (ms != 0) @(negedge clk);
        opcode = op;
        @(negedge clk);
        while (ms != 0) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        run_instr(6'h00);  // R8
        run_instr(6'h23);  // R6
        run_instr(6'h2B);  // R7
        run_instr(6'h04);  // R9
        run_instr(6'h02);  // R10
        run_instr(6'h3F);  // R4 undefined
        run_instr(6'h01);  // R4 undefined
        run_instr(6'h2B);
        run_instr(6'h23);
        run_instr(6'h22);  // R4 undefined near load
        run_instr(6'h04);
        // R1: reset in the middle of a load
        opcode = 6'h23;
        @(negedge clk);
        while (ms != 3) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        run_instr(6'h00);
        run_instr(6'h02);
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule